// File: doc/BRIEF.md
# Sensor Register Port over a Two-Wire Serial Bus

This block is the two-wire serial (I2C) slave that sits in front of a tilt and shake sensing core. It answers at the 7-bit bus address 0x2A and exposes a small byte-wide register map. Through this map a bus master reads the two axis samples and a status byte, and writes one configuration byte. The configuration byte holds the power-down flag and the detector settings, and its fields leave the block as plain outputs.

The serial clock and data lines arrive already synchronized to the system clock. The block drives SDA only through an active-high pull-low enable, and the pad is open drain. A register pointer is loaded by the first byte of a write and advances after every byte moved in either direction. A sticky interrupt flag is raised by the sensing core's event pulses and is cleared when the status byte is fetched for sending.

The power-down flag also gates the sample strobe that paces the detectors. The bus side stays responsive while the core is powered down.

Top module: `i2cs_sensor_if`

## Requirements
- R1: An address byte whose upper seven bits equal 0x2A is acknowledged, and bit 0 selects the direction (1 = read). Any other address gets no acknowledge, and every following bus bit is ignored until the next START.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After STOP, and out of reset, `sda_oe` is 0.
- R3: In a write, the first byte after the address loads the register pointer. Each later byte goes to the pointed register and then advances the pointer by one. Every byte is acknowledged.
- R4: A read is a pointer write, then a repeated START, then the address with the read bit set. Bytes go out MSB first, and the pointer advances after each byte is loaded for sending.
- R5: When the master does not acknowledge a read byte, the block releases SDA before the next SCL rise and sends nothing more until a new START.
- R6: Reads return X at 0x00 and Y at 0x01. They return STATUS at 0x02, laid out as bit7 interrupt flag, bits6:5 shake, bit4 tilt, bits3:2 instant orientation and bits1:0 settled orientation. Every other address, the configuration address 0x04 included, reads 0x00.
- R7: Writes to 0x00, 0x01 and 0x02 are acknowledged but change no state.
- R8: Writes to 0x04 set the configuration byte. Its fields are bit7 `cfg_pd`, bits6:5 `cfg_shth`, bits4:3 `cfg_shc`, bits2:1 `cfg_orc` and bit0 `cfg_shm`. The byte resets to 0x00.
- R9: A one-cycle pulse on `evt_orient` or `evt_shake` sets `int_o` on the next clock edge. `int_o` then stays high until STATUS is read.
- R10: Loading STATUS for sending captures the current flag and clears it in that same cycle. An event that arrives while that byte is still shifting leaves `int_o` high afterwards.
- R11: While `cfg_pd` is 1, `smp_out` is 0. Otherwise `smp_out` follows `smp_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line (bus level) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| x_in | input | 8 | X axis sample |
| y_in | input | 8 | Y axis sample |
| st_sh | input | 2 | Shake direction field |
| st_tilt | input | 1 | Tilt (measurement invalid) flag |
| st_ori | input | 2 | Instant orientation |
| st_or | input | 2 | Settled orientation |
| evt_orient | input | 1 | Pulse: settled orientation changed |
| evt_shake | input | 1 | Pulse: shake detected |
| smp_in | input | 1 | Raw detector sample strobe |
| smp_out | output | 1 | Sample strobe gated by power-down |
| int_o | output | 1 | Interrupt output |
| cfg_pd | output | 1 | Power-down flag |
| cfg_shth | output | 2 | Shake threshold select |
| cfg_shc | output | 2 | Shake window count select |
| cfg_orc | output | 2 | Orientation count select |
| cfg_shm | output | 1 | Shake mode |

## Verification
The bench sends an address that differs from 0x2A and then a configuration write. A design that only compared some address bits, or that woke up mid-frame, would acknowledge it and change the configuration. A single frame writes both an unmapped address and the configuration byte, and a second frame writes all three read-only addresses. A pointer that failed to advance, or that let read-only writes land, would leave the wrong configuration. A multi-byte read walks from X past STATUS into the unmapped space and ends on a NACK. This catches a pointer that advances on the wrong edge, a misordered status field, and a slave that keeps SDA low after the NACK. A final read fires a shake event partway through shifting STATUS. A design that cleared the flag at the end of the byte rather than at load time would lose that event.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_st_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } byte_kind_e;

  localparam logic [7:0] RA_X    = 8'h00;
  localparam logic [7:0] RA_Y    = 8'h01;
  localparam logic [7:0] RA_STAT = 8'h02;
  localparam logic [7:0] RA_CFG  = 8'h04;
endpackage

// File: rtl/i2cs_line_edges.sv
module i2cs_line_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cs_proto.sv
module i2cs_proto
  import i2cs_pkg::*;
#(
  parameter int              DW       = 8,
  parameter logic [DW-2:0]   SLV_ADDR = 7'h2A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_c,
  input  logic          stop_c,
  input  logic          sda_i,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe,
  output logic [DW-1:0] reg_ptr,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data,
  output logic          rd_stb
);
  localparam int            CW       = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  bus_st_e    st_q, st_d;
  byte_kind_e kind_q, kind_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d, ptr_q, ptr_d;
  logic rw_q, rw_d, mack_q, mack_d, oe_q, oe_d, load_c;

  // next-state process
  always_comb begin
    st_d = st_q; kind_d = kind_q; cnt_d = cnt_q; sh_d = sh_q;
    ptr_d = ptr_q; rw_d = rw_q; mack_d = mack_q; oe_d = oe_q;
    wr_stb = 1'b0; rd_stb = 1'b0; load_c = 1'b0;
    if (stop_c) begin
      st_d = ST_IDLE; oe_d = 1'b0;
    end else if (start_c) begin
      st_d = ST_RX; kind_d = BK_ADDR; cnt_d = '0; oe_d = 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[DW-2:0], sda_i};
            cnt_d = cnt_q + CW'(1);
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            cnt_d = '0;
            st_d  = ST_RX_ACK;
            oe_d  = 1'b1;
            case (kind_q)
              BK_ADDR: begin
                if (sh_q[DW-1:1] == SLV_ADDR) rw_d = sh_q[0];
                else begin st_d = ST_IDLE; oe_d = 1'b0; end
              end
              BK_PTR:  ptr_d = sh_q;
              default: begin wr_stb = 1'b1; ptr_d = ptr_q + DW'(1); end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            oe_d = 1'b0;
            if (kind_q == BK_ADDR && rw_q) load_c = 1'b1;
            else begin
              st_d   = ST_RX;
              kind_d = (kind_q == BK_ADDR) ? BK_PTR : BK_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              oe_d = 1'b0; st_d = ST_TX_ACK;
            end else begin
              sh_d  = {sh_q[DW-2:0], 1'b0};
              oe_d  = ~sh_q[DW-2];
              cnt_d = cnt_q + CW'(1);
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack_d = ~sda_i;
          else if (scl_fall) begin
            if (mack_q) load_c = 1'b1;
            else st_d = ST_IDLE;
          end
        end
        default: ;
      endcase
      if (load_c) begin
        rd_stb = 1'b1;
        sh_d   = rd_data;
        oe_d   = ~rd_data[DW-1];
        ptr_d  = ptr_q + DW'(1);
        cnt_d  = '0;
        st_d   = ST_TX;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; kind_q <= BK_ADDR; cnt_q <= '0; sh_q <= '0;
      ptr_q <= '0; rw_q <= 1'b0; mack_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      st_q <= st_d; kind_q <= kind_d; cnt_q <= cnt_d; sh_q <= sh_d;
      ptr_q <= ptr_d; rw_q <= rw_d; mack_q <= mack_d; oe_q <= oe_d;
    end
  end

  assign sda_oe  = oe_q;
  assign reg_ptr = ptr_q;
  assign wr_data = sh_q;

  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st_q == ST_IDLE && !oe_q));
  p_tx_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX) |-> (cnt_q < CNT_FULL));
  p_nack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX_ACK && scl_fall && !mack_q && !start_c && !stop_c)
      |=> (st_q == ST_IDLE && !oe_q));
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, rd_stb}));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start_c) |=> !oe_q);
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile
  import i2cs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] addr,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_stb,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] y_in,
  input  logic [1:0]    st_sh,
  input  logic          st_tilt,
  input  logic [1:0]    st_ori,
  input  logic [1:0]    st_or,
  input  logic          evt_orient,
  input  logic          evt_shake,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] cfg_q,
  output logic          int_o
);
  logic [DW-1:0] cfg_d;
  logic int_q, int_d, set_c, clr_c;

  assign set_c = evt_orient | evt_shake;
  assign clr_c = rd_stb && (addr == RA_STAT);

  always_comb begin
    cfg_d = cfg_q;
    if (wr_stb && addr == RA_CFG) cfg_d = wr_data;
    int_d = set_c | (int_q & ~clr_c);
  end

  always_comb begin
    case (addr)
      RA_X:    rd_data = x_in;
      RA_Y:    rd_data = y_in;
      RA_STAT: rd_data = DW'({int_q, st_sh, st_tilt, st_ori, st_or});
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      int_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      int_q <= int_d;
    end
  end

  assign int_o = int_q;

  p_int_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q && !clr_c) |=> int_q);
  p_int_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_c |=> int_q);
  p_int_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_c && !set_c) |=> !int_q);
  p_ro_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr < RA_CFG) |=> $stable(cfg_q));
endmodule

// File: rtl/i2cs_sensor_if.sv
module i2cs_sensor_if
  import i2cs_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-2:0] SLV_ADDR = 7'h2A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] y_in,
  input  logic [1:0]    st_sh,
  input  logic          st_tilt,
  input  logic [1:0]    st_ori,
  input  logic [1:0]    st_or,
  input  logic          evt_orient,
  input  logic          evt_shake,
  input  logic          smp_in,
  output logic          smp_out,
  output logic          int_o,
  output logic          cfg_pd,
  output logic [1:0]    cfg_shth,
  output logic [1:0]    cfg_shc,
  output logic [1:0]    cfg_orc,
  output logic          cfg_shm
);
  logic [1:0] rs_q;
  logic rst_int_n;
  logic scl_rise, scl_fall, start_c, stop_c, wr_stb, rd_stb;
  logic [DW-1:0] reg_ptr, wr_data, rd_data, cfg_q;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  i2cs_line_edges u_edges (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  i2cs_proto #(.DW(DW), .SLV_ADDR(SLV_ADDR)) u_proto (
    .clk(clk), .rst_n(rst_int_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c), .sda_i(sda_i), .rd_data(rd_data),
    .sda_oe(sda_oe), .reg_ptr(reg_ptr), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb)
  );

  i2cs_regfile #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .addr(reg_ptr), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_stb(rd_stb), .x_in(x_in), .y_in(y_in),
    .st_sh(st_sh), .st_tilt(st_tilt), .st_ori(st_ori), .st_or(st_or),
    .evt_orient(evt_orient), .evt_shake(evt_shake), .rd_data(rd_data),
    .cfg_q(cfg_q), .int_o(int_o)
  );

  assign cfg_pd   = cfg_q[7];
  assign cfg_shth = cfg_q[6:5];
  assign cfg_shc  = cfg_q[4:3];
  assign cfg_orc  = cfg_q[2:1];
  assign cfg_shm  = cfg_q[0];
  assign smp_out  = smp_in & ~cfg_q[7];

  p_pd_gate_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_pd |-> !smp_out);
endmodule

// File: tb/sim_i2cs_sensor_if.sv
module sim_i2cs_sensor_if;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, smp_out, int_o, cfg_pd, cfg_shm;
  logic [1:0] cfg_shth, cfg_shc, cfg_orc;
  logic [7:0] x_in = 8'h00, y_in = 8'h00;
  logic [1:0] st_sh = 2'b00, st_ori = 2'b00, st_or = 2'b00;
  logic st_tilt = 1'b0, evt_orient = 1'b0, evt_shake = 1'b0, smp_in = 1'b0;
  wire  sda_bus = m_sda & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] act_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cs_sensor_if u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .x_in(x_in), .y_in(y_in), .st_sh(st_sh), .st_tilt(st_tilt), .st_ori(st_ori),
    .st_or(st_or), .evt_orient(evt_orient), .evt_shake(evt_shake),
    .smp_in(smp_in), .smp_out(smp_out), .int_o(int_o), .cfg_pd(cfg_pd),
    .cfg_shth(cfg_shth), .cfg_shc(cfg_shc), .cfg_orc(cfg_orc), .cfg_shm(cfg_shm)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cfg_now();
    return {cfg_pd, cfg_shth, cfg_shc, cfg_orc, cfg_shm};
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; tick(QTR); m_scl = 1'b1; tick(QTR);
    m_sda = 1'b0; tick(QTR); m_scl = 1'b0; tick(QTR);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(QTR); m_scl = 1'b1; tick(QTR); m_sda = 1'b1; tick(QTR);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(QTR); m_scl = 1'b1; tick(QTR); m_scl = 1'b0; tick(QTR);
    end
    m_sda = 1'b1; tick(QTR); m_scl = 1'b1; tick(QTR/2);
    ack = ~sda_bus; tick(QTR/2); m_scl = 1'b0; tick(QTR);
  endtask

  // driver half of the scoreboard: expected byte queued before the read
  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_q.push_back(v); tag_q.push_back(tag);
  endtask

  task automatic recv_byte(input logic give_ack, input int evt_at);
    logic [7:0] b = '0;
    for (int i = 0; i < 8; i++) begin
      m_sda = 1'b1; tick(QTR);
      if (i == evt_at) begin evt_shake = 1'b1; tick(1); evt_shake = 1'b0; end
      m_scl = 1'b1; tick(QTR/2); b = {b[6:0], sda_bus}; tick(QTR/2);
      m_scl = 1'b0; tick(QTR);
    end
    act_q.push_back(b);
    m_sda = ~give_ack; tick(QTR); m_scl = 1'b1; tick(QTR); m_scl = 1'b0; tick(1);
    m_sda = 1'b1; tick(QTR);
  endtask

  // monitor half of the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      if (act_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        check(t, a, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic ack;
    tick(4); rst_n = 1'b1; tick(6);
    check("R8 reset cfg", cfg_now(), 8'h00);
    check("R9 reset int", int_o, 0);
    check("R2 reset sda_oe", sda_oe, 0);

    // R1: foreign address, then bytes that would write the config
    bus_start(); send_byte(8'h56, ack); check("R1 no ack for 0x2B", ack, 0);
    send_byte(8'h04, ack); check("R1 ignored ptr byte", ack, 0);
    send_byte(8'hFF, ack); check("R1 ignored data byte", ack, 0);
    bus_stop(); check("R1 cfg untouched", cfg_now(), 8'h00);

    // R8: config write and field layout
    bus_start(); send_byte(8'h54, ack); check("R1 ack for 0x2A", ack, 1);
    send_byte(8'h04, ack); check("R3 ptr ack", ack, 1);
    send_byte(8'hA5, ack); check("R3 data ack", ack, 1);
    bus_stop(); tick(2);
    check("R2 released after stop", sda_oe, 0);
    check("R8 pd", cfg_pd, 1); check("R8 shth", cfg_shth, 1);
    check("R8 shc", cfg_shc, 0); check("R8 orc", cfg_orc, 2);
    check("R8 shm", cfg_shm, 1);
    smp_in = 1'b1; #1; check("R11 strobe gated", smp_out, 0); tick(1); smp_in = 1'b0;

    // R3: pointer advances from unmapped 0x03 into 0x04
    bus_start(); send_byte(8'h54, ack); send_byte(8'h03, ack);
    send_byte(8'h11, ack); send_byte(8'h5A, ack); bus_stop(); tick(2);
    check("R3 auto-increment write", cfg_now(), 8'h5A);
    smp_in = 1'b1; #1; check("R11 strobe passes", smp_out, 1); tick(1); smp_in = 1'b0;

    // R7: writes to read-only addresses
    bus_start(); send_byte(8'h54, ack); send_byte(8'h00, ack);
    send_byte(8'hFF, ack); check("R7 ack X", ack, 1);
    send_byte(8'hFF, ack); check("R7 ack Y", ack, 1);
    send_byte(8'hFF, ack); check("R7 ack STATUS", ack, 1);
    bus_stop(); tick(2);
    check("R7 cfg unchanged", cfg_now(), 8'h5A);
    check("R7 int unchanged", int_o, 0);

    // R9: sticky interrupt
    x_in = 8'h9C; y_in = 8'h3E; st_sh = 2'b10; st_tilt = 1'b1;
    st_ori = 2'b01; st_or = 2'b11;
    evt_orient = 1'b1; tick(1); evt_orient = 1'b0; tick(1);
    check("R9 int set", int_o, 1); tick(50); check("R9 int held", int_o, 1);

    // R4/R6/R10/R5: multi-byte read across the map
    expect_byte(8'h9C, "R6 X"); expect_byte(8'h3E, "R4 Y after X");
    expect_byte(8'hD7, "R6 STATUS with INT"); expect_byte(8'h00, "R6 unmapped 0x03");
    expect_byte(8'h00, "R6 cfg reads zero");
    bus_start(); send_byte(8'h54, ack); send_byte(8'h00, ack);
    bus_start(); send_byte(8'h55, ack); check("R4 read address ack", ack, 1);
    recv_byte(1'b1, -1); recv_byte(1'b1, -1); recv_byte(1'b1, -1);
    recv_byte(1'b1, -1); recv_byte(1'b0, -1);
    check("R5 released after nack", sda_oe, 0);
    m_scl = 1'b1; tick(QTR); check("R5 no drive after nack", sda_oe, 0);
    m_scl = 1'b0; tick(QTR);
    bus_stop(); tick(2);
    check("R10 int cleared by read", int_o, 0);

    // R10: event while STATUS is shifting
    expect_byte(8'h57, "R10 STATUS captured at load");
    bus_start(); send_byte(8'h54, ack); send_byte(8'h02, ack);
    bus_start(); send_byte(8'h55, ack); recv_byte(1'b0, 3); bus_stop(); tick(2);
    check("R10 event kept", int_o, 1);
    expect_byte(8'hD7, "R9 STATUS shows kept event");
    bus_start(); send_byte(8'h54, ack); send_byte(8'h02, ack);
    bus_start(); send_byte(8'h55, ack); recv_byte(1'b0, -1); bus_stop(); tick(2);
    check("R10 int cleared again", int_o, 0);

    tick(10);
    if (exp_q.size() != 0 || act_q.size() != 0)
      check("R4 scoreboard drained", act_q.size(), exp_q.size());
    finish_run();
  end
endmodule